// File: doc/BRIEF.md
# Variable-Length Double-Buffered Serial Receive Shifter

This block collects serial bits arriving on one data line into words of a programmable length between 1 and 32 bits. Bit timing and start-bit detection are handled elsewhere. Upstream logic raises a single-cycle shift strobe for every bit it wants captured. Each accepted bit is placed directly at the tap that matches the configured word length, and the bits already held move one place toward bit 0. When the word is complete it is therefore already right-aligned, and no justification step follows the last bit.

A small down-counter tracks the bits still missing from the current word. On the strobe that completes a word, the finished value is copied in parallel into a 32-bit holding register. In the same edge the shift register is emptied and the counter reloads. The next word can start on the very next strobe, so words stream with no idle cycles between them. A ready flag shows that the holding register carries a word nobody has read yet, and it can serve as a flow-control handshake. An overrun flag records that a word was replaced before it was read.

Top module: `vlr_rx_shifter`

## Requirements
- R1: While reset is asserted and after it is released, word_o is all zeros and ready_o and overrun_o are low.
- R2: The length input holds the word length minus one (0 selects 1 bit, 31 selects 32 bits). The holding register takes a new word on the clock edge of exactly the L-th accepted bit of that word, and only on such an edge.
- R3: The first bit received of a word lands at bit 0 of word_o and the last lands at bit L-1, so the word needs no shifting.
- R4: All bits of word_o at position L and above read as zero, with no masking by the reader.
- R5: A bit is accepted only on a clock edge where shift_en is high. Edges with shift_en low leave the partial word and the bit count unchanged, whatever ser_in does.
- R6: Consecutive words need no gap: with a length of 8, four words complete in exactly 32 consecutive strobes.
- R7: ready_o rises on the edge that completes a word. rd_stb on an edge without a completion clears it. If rd_stb and a completion share an edge, ready_o stays high.
- R8: A completion while ready_o is high and rd_stb is low sets overrun_o and overwrites word_o with the new word. overrun_o stays set until an edge with rd_stb high and no new overrun.
- R9: Any change of the length input discards the partial word and restarts the bit count at the new length. A strobe on the edge where the change is taken is discarded too.
- R10: The two extreme lengths work: 32-bit words fill all of word_o, and 1-bit words complete on every accepted strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| shift_en | input | 1 | Accept ser_in on this edge |
| ser_in | input | 1 | Serial data bit |
| len_cfg | input | 5 | Word length minus one |
| rd_stb | input | 1 | Holding word consumed |
| word_o | output | 32 | Holding register, right-aligned word |
| ready_o | output | 1 | Holding register carries an unread word |
| overrun_o | output | 1 | A word was overwritten before being read |

## Verification
The hardest case to reach is an edge where a word completes and a read arrives at the same time. Getting there needs the first word already waiting, the next word one bit short of complete, and the read strobe driven together with that final bit. The bench builds this with 2-bit words, so the edge can be placed exactly. The length change in the middle of a word is also hard to reach. The bench applies it while a strobe is active, so a discarded bit would corrupt the next word if it were kept.

// File: rtl/vlr_pkg.sv
package vlr_pkg;
  localparam int unsigned VLR_WORD_W = 32;
  localparam int unsigned VLR_LEN_W  = $clog2(VLR_WORD_W);
endpackage

// File: rtl/vlr_bit_counter.sv
module vlr_bit_counter #(
  parameter int unsigned LW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_en,
  input  logic [LW-1:0] len_cfg,
  output logic [LW-1:0] len_q,
  output logic          len_chg,
  output logic          accept,
  output logic          term
);
  logic [LW-1:0] cnt_q, cnt_d;
  logic [LW-1:0] len_d;

  assign len_chg = (len_cfg != len_q);
  assign accept  = shift_en && !len_chg;
  assign term    = accept && (cnt_q == '0);

  always_comb begin
    len_d = len_q;
    cnt_d = cnt_q;
    if (len_chg) begin
      len_d = len_cfg;
      cnt_d = len_cfg;
    end else if (accept) begin
      if (term) cnt_d = len_q;
      else      cnt_d = cnt_q - {{(LW-1){1'b0}}, 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
      cnt_q <= '0;
    end else begin
      len_q <= len_d;
      cnt_q <= cnt_d;
    end
  end

  // R2: the remaining-bit count never exceeds the configured length
  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= len_q);

  // R5: no strobe and no length change keeps the count
  assert_cnt_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && !len_chg) |=> $stable(cnt_q));

  // R9: a length change restarts the count at the new length
  assert_cnt_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    len_chg |=> (cnt_q == len_q));
endmodule

// File: rtl/vlr_tap_shifter.sv
module vlr_tap_shifter #(
  parameter int unsigned W  = 32,
  parameter int unsigned LW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          clear,
  input  logic          term,
  input  logic          din,
  input  logic [LW-1:0] len,
  output logic [W-1:0]  word_next
);
  logic [W-1:0] sh_q, sh_d;
  logic [LW:0]  top_amt;

  // every bit either takes the incoming bit (its tap) or its upper neighbour
  for (genvar i = 0; i < W; i++) begin : g_tap
    if (i == W - 1) begin : g_top
      assign word_next[i] = (len == LW'(i)) ? din : 1'b0;
    end else begin : g_mid
      assign word_next[i] = (len == LW'(i)) ? din : sh_q[i+1];
    end
  end

  always_comb begin
    sh_d = sh_q;
    if (clear)       sh_d = '0;
    else if (accept) sh_d = term ? '0 : word_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign top_amt = {1'b0, len} + {{LW{1'b0}}, 1'b1};

  // R4: nothing ever sits above the configured tap
  assert_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_q >> top_amt) == '0);

  // R9: a length change empties the partial word
  assert_clear_on_chg_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (sh_q == '0));

  // R5: idle edges leave the partial word alone
  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && !clear) |=> $stable(sh_q));
endmodule

// File: rtl/vlr_hold_buf.sv
module vlr_hold_buf #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         xfer,
  input  logic [W-1:0] din,
  input  logic         rd_stb,
  output logic [W-1:0] word_q,
  output logic         ready_q,
  output logic         ovr_q
);
  logic [W-1:0] word_d;
  logic         ready_d, ovr_d;

  always_comb begin
    word_d  = word_q;
    ready_d = ready_q;
    ovr_d   = ovr_q;
    if (xfer) word_d = din;
    if (xfer)        ready_d = 1'b1;
    else if (rd_stb) ready_d = 1'b0;
    if (xfer && ready_q && !rd_stb) ovr_d = 1'b1;
    else if (rd_stb)                ovr_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      ready_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      word_q  <= word_d;
      ready_q <= ready_d;
      ovr_q   <= ovr_d;
    end
  end

  assert_ready_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> ready_q);

  assert_ready_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !xfer) |=> !ready_q);

  assert_overrun_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && ready_q && !rd_stb) |=> ovr_q);

  assert_hold_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer |=> $stable(word_q));
endmodule

// File: rtl/vlr_rx_shifter.sv
module vlr_rx_shifter
  import vlr_pkg::*;
#(
  parameter int unsigned W  = VLR_WORD_W,
  parameter int unsigned LW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_en,
  input  logic          ser_in,
  input  logic [LW-1:0] len_cfg,
  input  logic          rd_stb,
  output logic [W-1:0]  word_o,
  output logic          ready_o,
  output logic          overrun_o
);
  logic [1:0]    rst_sync_q;
  logic          rst_s;
  logic [LW-1:0] len_q;
  logic          len_chg, accept, term;
  logic [W-1:0]  word_next;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  vlr_bit_counter #(.LW(LW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_s),
    .shift_en (shift_en),
    .len_cfg  (len_cfg),
    .len_q    (len_q),
    .len_chg  (len_chg),
    .accept   (accept),
    .term     (term)
  );

  vlr_tap_shifter #(.W(W), .LW(LW)) u_shf (
    .clk       (clk),
    .rst_n     (rst_s),
    .accept    (accept),
    .clear     (len_chg),
    .term      (term),
    .din       (ser_in),
    .len       (len_q),
    .word_next (word_next)
  );

  vlr_hold_buf #(.W(W)) u_buf (
    .clk     (clk),
    .rst_n   (rst_s),
    .xfer    (term),
    .din     (word_next),
    .rd_stb  (rd_stb),
    .word_q  (word_o),
    .ready_q (ready_o),
    .ovr_q   (overrun_o)
  );

  // R1: out of reset nothing is pending
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_s |-> (!ready_o && !overrun_o && word_o == '0));
endmodule

// File: tb/sim_vlr_rx_shifter.sv
module sim_vlr_rx_shifter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        shift_en = 1'b0;
  logic        ser_in = 1'b0;
  logic [4:0]  len_cfg = 5'd7;
  logic        rd_stb = 1'b0;
  logic [31:0] word_o;
  logic        ready_o, overrun_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  vlr_rx_shifter u0 (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .ser_in(ser_in),
    .len_cfg(len_cfg), .rd_stb(rd_stb), .word_o(word_o),
    .ready_o(ready_o), .overrun_o(overrun_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_bit(logic b, logic rd);
    shift_en = 1'b1; ser_in = b; rd_stb = rd;
    @(negedge clk);
    shift_en = 1'b0; rd_stb = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      ser_in = ~ser_in;
      @(negedge clk);
    end
  endtask

  task automatic do_read();
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic set_len(int len);
    len_cfg = 5'(len - 1);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic send_word(logic [31:0] v, int len);
    for (int i = 0; i < len; i++) send_bit(v[i], 1'b0);
  endtask

  task automatic t_reset();
    chk("R1 word", word_o, 32'h0);
    chk("R1 ready", {31'b0, ready_o}, 32'h0);
    chk("R1 overrun", {31'b0, overrun_o}, 32'h0);
  endtask

  task automatic t_byte();
    logic [31:0] v = 32'hA5;
    set_len(8);
    for (int i = 0; i < 7; i++) send_bit(v[i], 1'b0);
    chk("R2 not ready after 7", {31'b0, ready_o}, 32'h0);
    send_bit(v[7], 1'b0);
    chk("R2 ready after 8", {31'b0, ready_o}, 32'h1);
    chk("R3 R4 byte value", word_o, 32'hA5);
    do_read();
    chk("R7 read clears ready", {31'b0, ready_o}, 32'h0);
  endtask

  task automatic t_gaps();
    logic [31:0] v = 32'h3C;
    for (int i = 0; i < 8; i++) begin
      send_bit(v[i], 1'b0);
      idle(i % 3 + 1);
    end
    chk("R5 gapped word", word_o, 32'h3C);
    chk("R5 gapped ready", {31'b0, ready_o}, 32'h1);
    do_read();
  endtask

  task automatic t_stream();
    logic [31:0] w [4] = '{32'h11, 32'hE7, 32'h80, 32'h5A};
    for (int k = 0; k < 4; k++) begin
      for (int i = 0; i < 8; i++) send_bit(w[k][i], (k > 0 && i == 0));
      chk("R6 stream word", word_o, w[k]);
      chk("R6 stream overrun", {31'b0, overrun_o}, 32'h0);
    end
    do_read();
  endtask

  task automatic t_overrun();
    set_len(4);
    send_word(32'h3, 4);
    chk("R8 first nibble", word_o, 32'h3);
    send_word(32'hC, 4);
    chk("R8 overrun set", {31'b0, overrun_o}, 32'h1);
    chk("R8 overwritten", word_o, 32'hC);
    do_read();
    chk("R8 read clears overrun", {31'b0, overrun_o}, 32'h0);
    chk("R7 read clears ready", {31'b0, ready_o}, 32'h0);
  endtask

  task automatic t_len_change();
    set_len(8);
    send_bit(1'b1, 1'b0); send_bit(1'b1, 1'b0); send_bit(1'b1, 1'b0);
    len_cfg = 5'd4; shift_en = 1'b1; ser_in = 1'b1;
    @(negedge clk);
    shift_en = 1'b0;
    for (int i = 0; i < 4; i++) send_bit(i[0] ? 1'b0 : 1'b1, 1'b0);
    chk("R9 not ready after 4", {31'b0, ready_o}, 32'h0);
    send_bit(1'b1, 1'b0);
    chk("R9 restarted word", word_o, 32'h15);
    do_read();
  endtask

  task automatic t_extremes();
    set_len(32);
    send_word(32'hDEADBEEF, 32);
    chk("R10 32-bit word", word_o, 32'hDEADBEEF);
    do_read();
    set_len(1);
    send_bit(1'b1, 1'b0);
    chk("R10 1-bit one", word_o, 32'h1);
    send_bit(1'b0, 1'b1);
    chk("R10 1-bit zero", word_o, 32'h0);
    chk("R10 1-bit no overrun", {31'b0, overrun_o}, 32'h0);
    do_read();
  endtask

  task automatic t_read_collide();
    set_len(2);
    send_word(32'h2, 2);
    send_bit(1'b1, 1'b0);
    send_bit(1'b1, 1'b1);
    chk("R7 ready kept on collide", {31'b0, ready_o}, 32'h1);
    chk("R8 no overrun on collide", {31'b0, overrun_o}, 32'h0);
    chk("R7 collide word", word_o, 32'h3);
    do_read();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_byte();
    t_gaps();
    t_stream();
    t_overrun();
    t_len_change();
    t_extremes();
    t_read_collide();
    done = 1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule